// File: doc/BRIEF.md
# Throttle State Encoder and Aggregator

This block produces the single 4-bit flow-control code that a readout board sends upstream to slow or stop trigger requests. It forms a local state from the occupancy count of a trigger-request FIFO. The local state steps through ready, overflow warning, busy and sync lost, and the thresholds in each direction differ so the state does not chatter. It then merges this local state with twelve 4-bit codes reported by downstream cards, and the most severe state wins.

Outside run mode the block sends busy no matter what its inputs are. It also gives a 5-bit one-hot status of the merged state for monitoring. A one-cycle strobe marks every cycle in which the outgoing code takes a new value, so that the link logic can send a control word at once. A sync-lost condition seen locally holds until a resync pulse or a reset clears it.

Top module: `throttle_aggregator`

## Requirements
- R1: While reset is asserted and after it is released, until the first clock edge with reset released, `mergedCode` is 0100, `mergedStatus` is 00010 and `codeChanged` is 0.
- R2: When `runMode` is low at a clock edge, `mergedCode` becomes 0100 and `mergedStatus` becomes 00010 after that edge. This holds whatever the remote codes and the local state are.
- R3: The output encodings are: ready gives code 1000 and status 00000; overflow warning gives 0001 and 00001; busy gives 0100 and 00010; sync lost gives 0010 and 00100; error gives 1100 and 01000; disconnected gives 0000 and 10000.
- R4: A remote code of 0000 or 1111 counts as disconnected. 1100 counts as error, 0010 as sync lost, 0100 as busy, 0001 as warning and 1000 as ready. Any other remote code counts as error.
- R5: The merged state is the most severe of the thirteen sources. From highest to lowest the order is disconnected, error, sync lost, busy, warning, ready.
- R6: The local state goes from ready to warning when the FIFO level is 192 or more. It goes back from warning to ready when the level is 191 or less. Both thresholds are parameters.
- R7: The local state goes from warning to busy when the level is 224 or more. It goes back from busy to warning when the level is 223 or less.
- R8: The local state goes from busy to sync lost when the level is 225 or more. Sync lost holds whatever the level is, until a reset or a high `resyncPulse` at a clock edge returns the local state to ready.
- R9: The local state moves by at most one step per clock edge, so a level far above every threshold walks the state up one step per cycle.
- R10: `codeChanged` is high for exactly the cycles in which `mergedCode` differs from its value in the cycle before.
- R11: A change in a remote code or in `runMode` shows at the outputs one clock edge after it is sampled. A change in the FIFO level or in `resyncPulse` shows two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| runMode | input | 1 | High while the system is taking data |
| resyncPulse | input | 1 | Clears a sticky local sync-lost state |
| fifoLevel | input | 9 | Entry count of the trigger-request FIFO |
| remoteCodes | input | 48 | Twelve 4-bit remote codes; card k uses bits 4k+3..4k |
| mergedCode | output | 4 | Merged throttle code |
| mergedStatus | output | 5 | One-hot merged status (bit 4 disconnected down to bit 0 warning) |
| codeChanged | output | 1 | High in the first cycle of each new code value |

## Verification
The remote codes and the run flag pass through one register, so their effect is due one edge after they are sampled. The FIFO level and the resync pulse pass through the hysteresis register and then the output register, so their effect is due one edge later than that. The strobe is due in the same cycle as the code it announces. The bench changes its inputs on the falling edge. After each rising edge it advances a reference model by one step, using the inputs that edge saw, and compares code, status and strobe at the next falling edge. Every cycle is compared, so a result that arrives one cycle early or late is reported.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

  localparam logic [3:0] CODE_READY = 4'b1000;
  localparam logic [3:0] CODE_WARN  = 4'b0001;
  localparam logic [3:0] CODE_SYNC  = 4'b0010;
  localparam logic [3:0] CODE_BUSY  = 4'b0100;
  localparam logic [3:0] CODE_ERR   = 4'b1100;
  localparam logic [3:0] CODE_DISC  = 4'b0000;

  localparam logic [4:0] STAT_BUSY = 5'b00010;

  // strobes from the hysteresis control to the merge datapath
  typedef struct packed {
    logic warn;
    logic busy;
    logic sync;
  } localFlags_t;

  function automatic logic [4:0] codeToStatus(input logic [3:0] c);
    logic [4:0] s;
    case (c)
      4'b0000, 4'b1111: s = 5'b10000;
      4'b1100:          s = 5'b01000;
      4'b0010:          s = 5'b00100;
      4'b0100:          s = 5'b00010;
      4'b0001:          s = 5'b00001;
      4'b1000:          s = 5'b00000;
      default:          s = 5'b01000;  // unknown value: error
    endcase
    return s;
  endfunction

  function automatic logic [3:0] statusToCode(input logic [4:0] s);
    logic [3:0] c;
    case (s)
      5'b10000: c = CODE_DISC;
      5'b01000: c = CODE_ERR;
      5'b00100: c = CODE_SYNC;
      5'b00010: c = CODE_BUSY;
      5'b00001: c = CODE_WARN;
      default:  c = CODE_READY;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import throttle_pkg::*;
#(
  parameter int LEVEL_W    = 9,
  parameter int WARN_ENTER = 192,
  parameter int WARN_EXIT  = 191,
  parameter int BUSY_ENTER = 224,
  parameter int BUSY_EXIT  = 223,
  parameter int SYNC_ENTER = 225
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic               resyncPulse,
  output localFlags_t        flags
);

  localparam logic [LEVEL_W-1:0] warnEnterLvl = LEVEL_W'(WARN_ENTER);
  localparam logic [LEVEL_W-1:0] warnExitLvl  = LEVEL_W'(WARN_EXIT);
  localparam logic [LEVEL_W-1:0] busyEnterLvl = LEVEL_W'(BUSY_ENTER);
  localparam logic [LEVEL_W-1:0] busyExitLvl  = LEVEL_W'(BUSY_EXIT);
  localparam logic [LEVEL_W-1:0] syncEnterLvl = LEVEL_W'(SYNC_ENTER);

  typedef enum logic [1:0] {ST_READY, ST_WARN, ST_BUSY, ST_SYNC} fillState_t;

  fillState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_READY: if (fifoLevel >= warnEnterLvl) stateNext = ST_WARN;
      ST_WARN: begin
        if (fifoLevel >= busyEnterLvl)     stateNext = ST_BUSY;
        else if (fifoLevel <= warnExitLvl) stateNext = ST_READY;
      end
      ST_BUSY: begin
        if (fifoLevel >= syncEnterLvl)     stateNext = ST_SYNC;
        else if (fifoLevel <= busyExitLvl) stateNext = ST_WARN;
      end
      ST_SYNC: if (resyncPulse) stateNext = ST_READY;
      default: stateNext = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_READY;
    else        state <= stateNext;
  end

  assign flags.warn = (state == ST_WARN);
  assign flags.busy = (state == ST_BUSY);
  assign flags.sync = (state == ST_SYNC);

endmodule

// File: rtl/throttle_dp.sv
module throttle_dp
  import throttle_pkg::*;
#(
  parameter int NUM_REMOTE = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    runMode,
  input  logic [NUM_REMOTE*4-1:0] remoteCodes,
  input  localFlags_t             flags,
  output logic [3:0]              mergedCode,
  output logic [4:0]              mergedStatus,
  output logic                    codeChanged
);

  logic [4:0] remoteStat [NUM_REMOTE];
  logic [4:0] anyStat;
  logic [4:0] pickStat;
  logic [4:0] nextStat;
  logic [3:0] nextCode;

  for (genvar g = 0; g < NUM_REMOTE; g++) begin : g_decode
    assign remoteStat[g] = codeToStatus(remoteCodes[g*4 +: 4]);
  end

  always_comb begin
    anyStat = {2'b00, flags.sync, flags.busy, flags.warn};
    for (int i = 0; i < NUM_REMOTE; i++) anyStat = anyStat | remoteStat[i];
  end

  always_comb begin
    pickStat = 5'b00000;
    if (anyStat[4])      pickStat = 5'b10000;
    else if (anyStat[3]) pickStat = 5'b01000;
    else if (anyStat[2]) pickStat = 5'b00100;
    else if (anyStat[1]) pickStat = 5'b00010;
    else if (anyStat[0]) pickStat = 5'b00001;
  end

  assign nextStat = runMode ? pickStat : STAT_BUSY;
  assign nextCode = statusToCode(nextStat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mergedCode   <= CODE_BUSY;
      mergedStatus <= STAT_BUSY;
      codeChanged  <= 1'b0;
    end else begin
      mergedCode   <= nextCode;
      mergedStatus <= nextStat;
      codeChanged  <= (nextCode != mergedCode);
    end
  end

endmodule

// File: rtl/throttle_aggregator.sv
module throttle_aggregator
  import throttle_pkg::*;
#(
  parameter int NUM_REMOTE = 12,
  parameter int LEVEL_W    = 9,
  parameter int WARN_ENTER = 192,
  parameter int WARN_EXIT  = 191,
  parameter int BUSY_ENTER = 224,
  parameter int BUSY_EXIT  = 223,
  parameter int SYNC_ENTER = 225
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    runMode,
  input  logic                    resyncPulse,
  input  logic [LEVEL_W-1:0]      fifoLevel,
  input  logic [NUM_REMOTE*4-1:0] remoteCodes,
  output logic [3:0]              mergedCode,
  output logic [4:0]              mergedStatus,
  output logic                    codeChanged
);

  localFlags_t flags;

  throttle_ctrl #(
    .LEVEL_W(LEVEL_W), .WARN_ENTER(WARN_ENTER), .WARN_EXIT(WARN_EXIT),
    .BUSY_ENTER(BUSY_ENTER), .BUSY_EXIT(BUSY_EXIT), .SYNC_ENTER(SYNC_ENTER)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifoLevel(fifoLevel),
    .resyncPulse(resyncPulse), .flags(flags)
  );

  throttle_dp #(.NUM_REMOTE(NUM_REMOTE)) u_dp (
    .clk(clk), .rst_n(rst_n), .runMode(runMode), .remoteCodes(remoteCodes),
    .flags(flags), .mergedCode(mergedCode), .mergedStatus(mergedStatus),
    .codeChanged(codeChanged)
  );

endmodule

// File: rtl/throttle_aggregator_chk.sv
module throttle_aggregator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       runMode,
  input logic [3:0] mergedCode,
  input logic [4:0] mergedStatus,
  input logic       codeChanged
);

  assert_idle_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !runMode |=> (mergedCode == 4'b0100 && mergedStatus == 5'b00010));

  assert_status_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mergedStatus));

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mergedCode == 4'b1000 || mergedCode == 4'b0001 || mergedCode == 4'b0010 ||
     mergedCode == 4'b0100 || mergedCode == 4'b1100 || mergedCode == 4'b0000));

  assert_strobe_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    codeChanged |-> (mergedCode != $past(mergedCode)));

  assert_change_has_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mergedCode != $past(mergedCode)) |-> codeChanged);

endmodule

bind throttle_aggregator throttle_aggregator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .runMode(runMode), .mergedCode(mergedCode),
  .mergedStatus(mergedStatus), .codeChanged(codeChanged)
);

// File: tb/sim_throttle_aggregator.sv
module sim_throttle_aggregator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        runMode = 1'b0;
  logic        resyncPulse = 1'b0;
  logic [8:0]  fifoLevel = '0;
  logic [47:0] remoteCodes = {12{4'b1000}};
  logic [3:0]  mergedCode;
  logic [4:0]  mergedStatus;
  logic        codeChanged;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // reference model state
  int mLocal = 0;          // 0 ready, 1 warn, 2 busy, 3 sync
  logic [3:0] mCode = 4'b0100;
  logic [4:0] mStat = 5'b00010;
  logic mChg = 1'b0;

  always #5 clk = ~clk;

  throttle_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .runMode(runMode), .resyncPulse(resyncPulse),
    .fifoLevel(fifoLevel), .remoteCodes(remoteCodes), .mergedCode(mergedCode),
    .mergedStatus(mergedStatus), .codeChanged(codeChanged)
  );

  // severity 5 disconnected .. 0 ready
  function automatic int severity(input logic [3:0] c);
    if (c == 4'b0000 || c == 4'b1111) return 5;
    if (c == 4'b0010) return 3;
    if (c == 4'b0100) return 2;
    if (c == 4'b0001) return 1;
    if (c == 4'b1000) return 0;
    return 4;
  endfunction

  function automatic logic [3:0] sevCode(input int s);
    logic [3:0] t [6] = '{4'b1000, 4'b0001, 4'b0100, 4'b0010, 4'b1100, 4'b0000};
    return t[s];
  endfunction

  function automatic logic [4:0] sevStat(input int s);
    return (s == 0) ? 5'b0 : 5'(1 << (s - 1));
  endfunction

  task automatic modelStep();
    int worst;
    int nl;
    logic [3:0] nc;
    if (!rst_n) begin
      mLocal = 0; mCode = 4'b0100; mStat = 5'b00010; mChg = 1'b0;
      return;
    end
    worst = (mLocal == 3) ? 3 : (mLocal == 2) ? 2 : (mLocal == 1) ? 1 : 0;
    for (int k = 0; k < 12; k++)
      if (severity(remoteCodes[k*4 +: 4]) > worst) worst = severity(remoteCodes[k*4 +: 4]);
    if (!runMode) worst = 2;
    nc = sevCode(worst);
    mChg = (nc != mCode);
    mCode = nc;
    mStat = sevStat(worst);
    nl = mLocal;
    if (mLocal == 0 && fifoLevel >= 192) nl = 1;
    else if (mLocal == 1 && fifoLevel >= 224) nl = 2;
    else if (mLocal == 1 && fifoLevel <= 191) nl = 0;
    else if (mLocal == 2 && fifoLevel >= 225) nl = 3;
    else if (mLocal == 2 && fifoLevel <= 223) nl = 1;
    else if (mLocal == 3 && resyncPulse) nl = 0;
    mLocal = nl;
  endtask

  task automatic compare();
    checks++;
    if (mergedCode !== mCode) begin
      errors++;
      $display("FAIL %s code actual %b expected %b at %0t", phase, mergedCode, mCode, $time);
    end
    checks++;
    if (mergedStatus !== mStat) begin
      errors++;
      $display("FAIL %s status actual %b expected %b at %0t", phase, mergedStatus, mStat, $time);
    end
    checks++;
    if (codeChanged !== mChg) begin
      errors++;
      $display("FAIL %s R10 strobe actual %b expected %b at %0t", phase, codeChanged, mChg, $time);
    end
  endtask

  // one clock: inputs already set at the falling edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      modelStep();
      compare();
    end
  endtask

  task automatic setRemote(input int idx, input logic [3:0] c);
    remoteCodes[idx*4 +: 4] = c;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset values
    phase = "R1";
    @(negedge clk);
    compare();
    tick(3);
    rst_n = 1'b1;
    compare();
    // R2: outside run mode busy is sent
    phase = "R2";
    tick(3);
    // R3: ready once running; R10 strobe on change; R11 one edge latency
    phase = "R3 R10 R11";
    runMode = 1'b1;
    tick(3);
    // R4: every remote code value on one card
    phase = "R4 R3";
    for (int v = 0; v < 16; v++) begin
      setRemote(5, 4'(v));
      tick(2);
    end
    setRemote(5, 4'b1000);
    tick(2);
    // R5: priority among sources
    phase = "R5";
    setRemote(0, 4'b0001); tick(2);
    setRemote(11, 4'b0100); tick(2);
    setRemote(3, 4'b0010); tick(2);
    setRemote(7, 4'b1100); tick(2);
    setRemote(9, 4'b1111); tick(2);
    setRemote(9, 4'b1000); tick(2);
    setRemote(7, 4'b1000); tick(2);
    setRemote(3, 4'b1000); tick(2);
    setRemote(11, 4'b1000); tick(2);
    setRemote(0, 4'b1000); tick(2);
    // R6: ready/warn hysteresis
    phase = "R6";
    fifoLevel = 9'd191; tick(3);
    fifoLevel = 9'd192; tick(3);
    fifoLevel = 9'd200; tick(3);
    fifoLevel = 9'd191; tick(3);
    fifoLevel = 9'd192; tick(3);
    // R7: warn/busy hysteresis
    phase = "R7";
    fifoLevel = 9'd224; tick(3);
    fifoLevel = 9'd223; tick(3);
    fifoLevel = 9'd224; tick(3);
    // R8: sync lost and its stickiness
    phase = "R8";
    fifoLevel = 9'd225; tick(3);
    fifoLevel = 9'd0; tick(4);
    phase = "R2 R8";
    runMode = 1'b0; tick(2);
    runMode = 1'b1; tick(2);
    phase = "R8 R11";
    resyncPulse = 1'b1; tick(1);
    resyncPulse = 1'b0; tick(3);
    // R9: single step per edge from far above all thresholds
    phase = "R9";
    fifoLevel = 9'd400; tick(6);
    phase = "R8 R9";
    resyncPulse = 1'b1; tick(1);
    resyncPulse = 1'b0; fifoLevel = 9'd0; tick(4);
    // R2 with a severe remote present
    phase = "R2";
    setRemote(2, 4'b0000); tick(2);
    runMode = 1'b0; tick(3);
    runMode = 1'b1; tick(2);
    setRemote(2, 4'b1000); tick(3);
    // R1: reset in mid run clears sync
    phase = "R1";
    fifoLevel = 9'd300; tick(5);
    rst_n = 1'b0; fifoLevel = 9'd0;
    #1;
    modelStep();
    compare();
    tick(2);
    rst_n = 1'b1;
    tick(3);
    finishRun();
  end

endmodule